// File: doc/BRIEF.md
# I2C Byte Master Controller

This block is a register-mapped I2C bus master that carries out one transaction at a time. Software programs a 7-bit target address together with a direction bit, then asks for a start condition. The block sends the address byte and reports the acknowledge. It then moves data one byte at a time through a single shared data port. Each byte is gated by a handshake in which software clears a status flag.

Status flags are cleared by writing 0 to them. They report address done, byte received, byte sent, transmit data empty, not-acknowledge, lost arbitration and stop done. A force-stop control bit has two uses: in a write it ends the transaction, and in a read it makes the next byte the last one, which is NACKed and followed by a stop. A pin override mode lets software drive SCL and SDA directly, for example to clock a stuck target free. Both lines are open-drain: each output enable pulls its line low, and a separate input samples the line level.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset every register reads 0 and both `scl_oe` and `sda_oe` are low, so both lines are released.
- R2: These registers read back what was written: control at 0x04, clock divider at 0x18, target address at 0x20 and data port at 0x24. In the address register, bits 7:1 hold the target and bit 0 set to 1 means read. Control bit 0 (start) always reads 0. One SCL quarter period lasts divider+1 clock cycles.
- R3: The status register at 0x0C has these bits: bit 0 address done, bit 1 byte received, bit 2 byte sent, bit 3 transmit data empty, bit 4 stop done, bit 5 arbitration lost, bit 6 NACK seen. Bit 7 reads 0. A write clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R4: A control write that sets bit 3 (master enable) and bit 0 (start) while the bus is idle produces a start condition and then sends the address byte, MSB first. When the target ACKs, status bit 0 sets, together with bit 1 for a read or bit 3 for a write.
- R5: In a write, a byte written to the data port is sent once status bit 3 is cleared. After the target ACKs it, status bits 2 and 3 set.
- R6: Clearing status bit 3 has no effect unless the data port was written after the previous byte was launched. While the block waits, it holds SCL low.
- R7: In a write, setting control bit 1 (force stop) while the block waits produces a stop condition. Status bit 4 then sets, both lines are released, and control bit 1 reads 0.
- R8: In a read, clearing status bit 1 receives one byte. The master ACKs the byte if control bit 1 was 0 when the byte started. The byte is then readable at the data port and status bit 1 sets.
- R9: In a read, if control bit 1 is 1 when a byte starts, that byte is NACKed and followed by a stop. Status bit 4 then sets.
- R10: If the address byte is NACKed, status bits 6 and 0 set, a stop follows and status bit 4 sets. Neither bit 1 nor bit 3 sets.
- R11: If a write data byte is NACKed, status bits 6 and 2 set, a stop follows and bit 3 stays clear.
- R12: If the block samples SDA low while it is releasing SDA to send a 1 bit, status bit 5 sets. Both lines are then released at once, no stop is generated and status bit 4 stays clear.
- R13: With control bit 4 set, `scl_oe` is the inverse of control bit 6 and `sda_oe` is the inverse of control bit 5. Protocol activity has no effect on the pins in this mode.
- R14: A start request whose control write does not set bit 3 is ignored: the lines stay released and status stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on `reg_addr`) |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The bench uses the default parameters, ADDR_W = 6 and DIV_W = 8, and programs a divider value of 2. Each bit then takes twelve clock cycles, which keeps full multi-byte reads and writes, NACK-terminated transfers and an arbitration loss short enough to run back to back. A behavioural open-drain target on the wired-AND lines checks every byte it receives against a queue of expected bytes. The same target returns read data and can force a NACK or hold SDA low, so that each protocol branch is reached from the bus side.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int ADDR_W = 6,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe
);

  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] OFS_DIV  = ADDR_W'(24);
  localparam logic [ADDR_W-1:0] OFS_ADR  = ADDR_W'(32);
  localparam logic [ADDR_W-1:0] OFS_DAT  = ADDR_W'(36);

  localparam int F_ADONE = 0;
  localparam int F_RXD   = 1;
  localparam int F_TXD   = 2;
  localparam int F_EMPTY = 3;
  localparam int F_STOP  = 4;
  localparam int F_ARB   = 5;
  localparam int F_NACK  = 6;

  typedef enum logic [2:0] {S_IDLE, S_START, S_XFER, S_WAIT, S_STOP} state_t;

  state_t           state;
  logic [7:0]       ctrl_q, adr_q, dat_q, sh_q;
  logic [6:0]       stat_q;
  logic [DIV_W-1:0] div_q, cnt_q;
  logic [1:0]       ph_q;
  logic [3:0]       bit_q;
  logic             scl_lo, sda_lo;
  logic             is_rx, is_adr, last_rx, nack_q, loaded;

  wire wr_ctrl  = reg_wr && (reg_addr == OFS_CTRL);
  wire wr_stat  = reg_wr && (reg_addr == OFS_STAT);
  wire wr_div   = reg_wr && (reg_addr == OFS_DIV);
  wire wr_adr   = reg_wr && (reg_addr == OFS_ADR);
  wire wr_dat   = reg_wr && (reg_addr == OFS_DAT);
  wire start_go = wr_ctrl && reg_wdata[3] && reg_wdata[0] && (state == S_IDLE);
  wire tick     = (cnt_q == '0) && (state != S_IDLE) && (state != S_WAIT);
  wire data_bit = (bit_q < 4'd8);
  wire out_bit  = data_bit ? (is_rx ? 1'b1 : sh_q[7]) : (is_rx ? last_rx : 1'b1);
  wire ovr      = ctrl_q[4];

  assign scl_oe = ovr ? !ctrl_q[6] : scl_lo;
  assign sda_oe = ovr ? !ctrl_q[5] : sda_lo;

  always_comb begin
    case (reg_addr)
      OFS_CTRL: reg_rdata = ctrl_q;
      OFS_STAT: reg_rdata = {1'b0, stat_q};
      OFS_DIV:  reg_rdata = 8'(div_q);
      OFS_ADR:  reg_rdata = adr_q;
      OFS_DAT:  reg_rdata = dat_q;
      default:  reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      ctrl_q  <= '0;
      stat_q  <= '0;
      div_q   <= '0;
      cnt_q   <= '0;
      adr_q   <= '0;
      dat_q   <= '0;
      sh_q    <= '0;
      ph_q    <= '0;
      bit_q   <= '0;
      scl_lo  <= 1'b0;
      sda_lo  <= 1'b0;
      is_rx   <= 1'b0;
      is_adr  <= 1'b0;
      last_rx <= 1'b0;
      nack_q  <= 1'b0;
      loaded  <= 1'b0;
    end else begin
      if (wr_stat) stat_q <= stat_q & reg_wdata[6:0];
      if (wr_ctrl) ctrl_q <= {reg_wdata[7:1], 1'b0};
      if (wr_div)  div_q  <= DIV_W'(reg_wdata);
      if (wr_adr)  adr_q  <= reg_wdata;
      if (wr_dat) begin
        dat_q  <= reg_wdata;
        loaded <= 1'b1;
      end

      if (state == S_IDLE || state == S_WAIT || tick) cnt_q <= div_q;
      else cnt_q <= cnt_q - DIV_W'(1);

      case (state)
        S_IDLE: begin
          ph_q <= '0;
          if (start_go) state <= S_START;
        end

        S_START: if (tick) begin
          ph_q <= ph_q + 2'd1;
          case (ph_q)
            2'd0: begin scl_lo <= 1'b0; sda_lo <= 1'b0; end
            2'd1: sda_lo <= 1'b1;
            2'd2: scl_lo <= 1'b1;
            2'd3: begin
              state  <= S_XFER;
              sh_q   <= adr_q;
              bit_q  <= '0;
              is_rx  <= 1'b0;
              is_adr <= 1'b1;
            end
          endcase
        end

        S_XFER: if (tick) begin
          ph_q <= ph_q + 2'd1;
          case (ph_q)
            2'd0: sda_lo <= !out_bit;
            2'd1: scl_lo <= 1'b0;
            2'd2: begin
              if (data_bit) begin
                if (is_rx) sh_q <= {sh_q[6:0], sda_in};
                else if (sh_q[7] && !sda_in) begin
                  state          <= S_IDLE;
                  scl_lo         <= 1'b0;
                  sda_lo         <= 1'b0;
                  stat_q[F_ARB]  <= 1'b1;
                end
              end else begin
                nack_q <= sda_in;
              end
            end
            2'd3: begin
              scl_lo <= 1'b1;
              if (data_bit) begin
                bit_q <= bit_q + 4'd1;
                if (!is_rx) sh_q <= {sh_q[6:0], 1'b0};
              end else if (is_adr) begin
                is_adr           <= 1'b0;
                stat_q[F_ADONE]  <= 1'b1;
                if (nack_q) begin
                  stat_q[F_NACK] <= 1'b1;
                  state          <= S_STOP;
                end else begin
                  state <= S_WAIT;
                  is_rx <= adr_q[0];
                  if (adr_q[0]) stat_q[F_RXD] <= 1'b1;
                  else stat_q[F_EMPTY] <= 1'b1;
                end
              end else if (is_rx) begin
                dat_q         <= sh_q;
                stat_q[F_RXD] <= 1'b1;
                state         <= last_rx ? S_STOP : S_WAIT;
              end else begin
                stat_q[F_TXD] <= 1'b1;
                if (nack_q) begin
                  stat_q[F_NACK] <= 1'b1;
                  state          <= S_STOP;
                end else begin
                  stat_q[F_EMPTY] <= 1'b1;
                  state           <= S_WAIT;
                end
              end
            end
          endcase
        end

        S_WAIT: begin
          ph_q <= '0;
          if (is_rx) begin
            if (!stat_q[F_RXD]) begin
              state   <= S_XFER;
              last_rx <= ctrl_q[1];
              bit_q   <= '0;
            end
          end else if (ctrl_q[1]) begin
            state <= S_STOP;
          end else if (!stat_q[F_EMPTY] && loaded) begin
            state  <= S_XFER;
            sh_q   <= dat_q;
            loaded <= 1'b0;
            bit_q  <= '0;
          end
        end

        S_STOP: if (tick) begin
          ph_q <= ph_q + 2'd1;
          case (ph_q)
            2'd0: sda_lo <= 1'b1;
            2'd1: scl_lo <= 1'b0;
            2'd2: sda_lo <= 1'b0;
            2'd3: begin
              state          <= S_IDLE;
              stat_q[F_STOP] <= 1'b1;
              ctrl_q[1]      <= 1'b0;
            end
          endcase
        end

        default: state <= S_IDLE;
      endcase
    end
  end

  // R12: losing arbitration leaves both lines released at once
  a_r12_release: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stat_q[F_ARB]) && !ovr) |-> (!scl_oe && !sda_oe));

  // R7: stop done is reported with the bus free
  a_r7_stop_released: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stat_q[F_STOP]) && !ovr) |-> (!scl_oe && !sda_oe));

  // R4: SDA is pulled low under a high SCL only to form a start condition
  a_r4_start_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_lo && $past(!scl_lo) && $rose(sda_lo)) |-> ($past(state) == S_START));

  // R7: SDA is released under a high SCL only to form a stop condition
  a_r7_stop_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_lo && $past(!scl_lo) && $fell(sda_lo)) |-> ($past(state) == S_STOP));

  // R6: SCL is held low while waiting for software
  a_r6_hold_scl: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT) |-> scl_lo);

  // R11: a NACK always leads into a stop
  a_r11_nack_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[F_NACK]) |-> (state == S_STOP));

endmodule

// File: tb/i2c_byte_master_tb.sv
module i2c_byte_master_tb_top;

  localparam logic [5:0] A_CTRL = 6'h04;
  localparam logic [5:0] A_STAT = 6'h0C;
  localparam logic [5:0] A_DIV  = 6'h18;
  localparam logic [5:0] A_ADR  = 6'h20;
  localparam logic [5:0] A_DAT  = 6'h24;
  localparam logic [6:0] TGT    = 7'h50;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       scl_oe, sda_oe, scl_in, sda_in;

  logic s_pull = 1'b0, jam_arm = 1'b0, jam_hold = 1'b0, nack_data = 1'b0;

  always #2 clk = ~clk;

  assign scl_in = ~scl_oe;
  assign sda_in = ~(sda_oe | s_pull | jam_hold);

  i2c_byte_master dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_in(scl_in),
    .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  logic [7:0] rd_q[$];
  int rx_cnt = 0, macks = 0, mnacks = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // target model and scoreboard monitor
  int   t_st = 0, t_bit = 0;
  bit   t_pscl = 1, t_psda = 1, t_adr = 0, t_match = 0, t_rd = 0, t_mack = 0;
  logic [7:0] t_byte = '0, t_tx = '0, t_exp;

  always @(negedge clk) begin
    if (!rst_n) begin
      t_st = 0; t_pscl = 1; t_psda = 1; s_pull = 0;
    end else begin
      if (scl_in && t_pscl && t_psda && !sda_in) begin
        t_st = 1; t_bit = 0; t_adr = 1; s_pull = 0;
        if (jam_arm) jam_hold = 1;
      end else if (scl_in && t_pscl && !t_psda && sda_in) begin
        t_st = 0; s_pull = 0;
      end else if (scl_in && !t_pscl) begin
        if (t_st == 1 && t_bit < 8) begin
          t_byte = {t_byte[6:0], sda_in}; t_bit++;
        end else if (t_st == 2 && t_bit == 8) t_mack = !sda_in;
      end else if (!scl_in && t_pscl) begin
        if (t_st == 1) begin
          if (t_bit == 8) begin
            rx_cnt++;
            if (exp_q.size() == 0) chk(0, "R5 unexpected byte at target", t_byte, 0);
            else begin
              t_exp = exp_q.pop_front();
              chk(t_byte == t_exp, "R4/R5 byte seen by target", t_byte, t_exp);
            end
            if (t_adr) begin
              t_match = (t_byte[7:1] == TGT); t_rd = t_byte[0]; s_pull = t_match;
            end else s_pull = !nack_data;
            t_bit = 9;
          end else if (t_bit == 9) begin
            s_pull = 0;
            if (t_adr && !t_match) t_st = 0;
            else if (t_adr && t_rd) begin
              t_st = 2; t_bit = 0;
              t_tx = (rd_q.size() != 0) ? rd_q.pop_front() : 8'hFF;
              s_pull = !t_tx[7];
            end else t_bit = 0;
            t_adr = 0;
          end
        end else if (t_st == 2) begin
          if (t_bit == 8) begin
            if (t_mack) begin
              macks++; t_bit = 0;
              t_tx = (rd_q.size() != 0) ? rd_q.pop_front() : 8'hFF;
              s_pull = !t_tx[7];
            end else begin
              mnacks++; t_st = 0; s_pull = 0;
            end
          end else begin
            t_bit++;
            s_pull = (t_bit < 8) ? !t_tx[7 - t_bit] : 1'b0;
          end
        end
      end
      t_pscl = scl_in; t_psda = sda_in;
    end
  end

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic wait_stat(input logic [7:0] m, input string tag);
    logic [7:0] v;
    bit done;
    done = 0; v = '0;
    for (int n = 0; n < 20000 && !done; n++) begin
      rd(A_STAT, v);
      done = ((v & m) == m);
    end
    if (!done) chk(0, tag, v, m);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
    finish_up();
  end

  initial begin
    logic [7:0] v, s;
    idle(5);
    rst_n = 1;
    idle(2);

    rd(A_STAT, v); chk(v == 8'h00, "R1 status after reset", v, 8'h00);
    rd(A_CTRL, v); chk(v == 8'h00, "R1 control after reset", v, 8'h00);
    chk({scl_oe, sda_oe} == 2'b00, "R1 lines released", {scl_oe, sda_oe}, 0);

    wr(A_DIV, 8'h02); rd(A_DIV, v); chk(v == 8'h02, "R2 divider readback", v, 8'h02);
    wr(A_ADR, 8'hA0); rd(A_ADR, v); chk(v == 8'hA0, "R2 address readback", v, 8'hA0);
    wr(A_DAT, 8'h6E); rd(A_DAT, v); chk(v == 8'h6E, "R2 data readback", v, 8'h6E);

    wr(A_CTRL, 8'h81); idle(60);
    chk({scl_oe, sda_oe} == 2'b00, "R14 start without enable", {scl_oe, sda_oe}, 0);
    rd(A_STAT, v); chk(v == 8'h00, "R14 status untouched", v, 8'h00);
    rd(A_CTRL, v); chk(v == 8'h80, "R2 start bit reads 0", v, 8'h80);

    // write transaction
    exp_q.push_back(8'hA0); exp_q.push_back(8'h3C); exp_q.push_back(8'hC5);
    wr(A_CTRL, 8'h89); wr(A_STAT, 8'h00);
    wait_stat(8'h09, "R4 write address phase");
    rd(A_STAT, v); chk(v == 8'h09, "R4 address done + empty", v, 8'h09);
    wr(A_DAT, 8'h3C); wr(A_STAT, 8'hF7);
    wait_stat(8'h0C, "R5 first byte");
    rd(A_STAT, v); chk(v == 8'h0D, "R5 sent + empty", v, 8'h0D);
    wr(A_DAT, 8'hC5); wr(A_STAT, 8'hF3);
    wait_stat(8'h0C, "R5 second byte");
    chk(rx_cnt == 3, "R5 target byte count", rx_cnt, 3);
    wr(A_STAT, 8'hF7); idle(200);
    chk(rx_cnt == 3, "R6 no launch without load", rx_cnt, 3);
    chk(scl_oe == 1'b1, "R6 SCL held low", scl_oe, 1);
    wr(A_CTRL, 8'h8A);
    wait_stat(8'h10, "R7 stop after force");
    chk({scl_oe, sda_oe} == 2'b00, "R7 lines released", {scl_oe, sda_oe}, 0);
    chk(exp_q.size() == 0, "R5 all bytes seen", exp_q.size(), 0);
    rd(A_CTRL, v); chk(v == 8'h88, "R7 force stop self-clears", v, 8'h88);

    rd(A_STAT, s); wr(A_STAT, 8'hFF); rd(A_STAT, v);
    chk(v == s, "R3 ones leave status", v, s);
    wr(A_STAT, 8'hEF); rd(A_STAT, v);
    chk(v == (s & 8'hEF), "R3 zero clears one bit", v, s & 8'hEF);

    // read transaction
    rd_q.push_back(8'h5A); rd_q.push_back(8'hA7); rd_q.push_back(8'h81);
    exp_q.push_back(8'hA1);
    wr(A_STAT, 8'h00); wr(A_ADR, 8'hA1); wr(A_CTRL, 8'h89);
    wait_stat(8'h03, "R4 read address phase");
    rd(A_STAT, v); chk(v == 8'h03, "R4 address done + received", v, 8'h03);
    wr(A_CTRL, 8'h88); wr(A_STAT, 8'hFD);
    wait_stat(8'h02, "R8 first read");
    rd(A_DAT, v); chk(v == 8'h5A, "R8 first read byte", v, 8'h5A);
    wr(A_STAT, 8'hFD);
    wait_stat(8'h02, "R8 second read");
    rd(A_DAT, v); chk(v == 8'hA7, "R8 second read byte", v, 8'hA7);
    wr(A_CTRL, 8'h8A); wr(A_STAT, 8'hFD);
    wait_stat(8'h02, "R9 last read");
    rd(A_DAT, v); chk(v == 8'h81, "R9 last read byte", v, 8'h81);
    wait_stat(8'h10, "R9 stop after last");
    chk(macks == 2, "R8 master ACK count", macks, 2);
    chk(mnacks == 1, "R9 master NACK count", mnacks, 1);
    chk({scl_oe, sda_oe} == 2'b00, "R9 lines released", {scl_oe, sda_oe}, 0);

    // address NACK
    exp_q.push_back(8'h44);
    wr(A_STAT, 8'h00); wr(A_ADR, 8'h44); wr(A_CTRL, 8'h89);
    wait_stat(8'h10, "R10 stop after address NACK");
    rd(A_STAT, v); chk(v == 8'h51, "R10 status on address NACK", v, 8'h51);

    // data NACK
    exp_q.push_back(8'hA0); exp_q.push_back(8'h99);
    nack_data = 1;
    wr(A_STAT, 8'h00); wr(A_ADR, 8'hA0); wr(A_CTRL, 8'h89);
    wait_stat(8'h09, "R11 address phase");
    wr(A_DAT, 8'h99); wr(A_STAT, 8'hF7);
    wait_stat(8'h10, "R11 stop after data NACK");
    rd(A_STAT, v); chk(v == 8'h55, "R11 status on data NACK", v, 8'h55);
    nack_data = 0;

    // arbitration loss
    wr(A_STAT, 8'h00); jam_arm = 1; wr(A_CTRL, 8'h89);
    wait_stat(8'h20, "R12 arbitration lost");
    idle(20);
    rd(A_STAT, v); chk(v == 8'h20, "R12 no stop after loss", v, 8'h20);
    chk({scl_oe, sda_oe} == 2'b00, "R12 lines released", {scl_oe, sda_oe}, 0);
    jam_arm = 0; jam_hold = 0; idle(20);

    // pin override
    wr(A_CTRL, 8'h70); idle(2);
    chk({scl_oe, sda_oe} == 2'b00, "R13 both forced high", {scl_oe, sda_oe}, 0);
    wr(A_CTRL, 8'h50); idle(2);
    chk({scl_oe, sda_oe} == 2'b01, "R13 SDA forced low", {scl_oe, sda_oe}, 1);
    wr(A_CTRL, 8'h70); wr(A_CTRL, 8'h30); idle(2);
    chk({scl_oe, sda_oe} == 2'b10, "R13 SCL forced low", {scl_oe, sda_oe}, 2);
    wr(A_CTRL, 8'h70); wr(A_CTRL, 8'h10); idle(2);
    chk({scl_oe, sda_oe} == 2'b11, "R13 both forced low", {scl_oe, sda_oe}, 3);
    wr(A_CTRL, 8'h00); idle(2);
    chk({scl_oe, sda_oe} == 2'b00, "R13 override off", {scl_oe, sda_oe}, 0);

    finish_up();
  end

endmodule